// File: doc/BRIEF.md
# Inferential lock queuing table

This block sits beside a core's private cache and keeps a small record of cache lines that a predictor has inferred to be locks. Records are found by the program counter of the synchronizing instruction. Each record holds the lock line address and one of three states: INVALID, PRESENT (the line is cached but no critical section is inferred) or HELD (a critical section is inferred to be running). Line fills and evictions from the cache, and acquire and release predictions from the lock predictor, move records between these states.

Exclusive-read requests from other cores that carry a low-priority tag are checked against the record. A request for a line that is not HELD is answered at once. A request for a HELD line is parked in a small queue and answered when the release is inferred. It is also answered when the line stops being HELD for any other reason, or when a bounded wait runs out. Answers leave on two ports: one for immediate grants and one for deferred grants. The deferred port flags grants that were forced by the timer.

Top module: `lockq_table`

## Requirements
- R1: After reset every record is INVALID and both grant outputs are low, so the first request for any address gets an immediate grant.
- R2: A fill allocates a record for its PC in state PRESENT (or updates an existing record with that PC). A request for a PRESENT line gets `imm_gnt_valid` with the request's id on the clock edge that samples the request.
- R3: An acquire whose PC and address match a PRESENT record makes it HELD. A request for that line while the queue has room gives no immediate grant and is queued.
- R4: An acquire whose PC has no live record, or whose address differs from the record's address, has no effect.
- R5: A release that matches a HELD record by PC makes it PRESENT. Queued requests for that line are then granted on `def_gnt_valid` with `def_gnt_expired` low. The first grant comes on the edge after the one that took the release, and the oldest request is granted first.
- R6: A request that is still queued is granted with `def_gnt_expired` high on the TIMEOUT+1-th edge after the edge that queued it. At the same edge its line's HELD record becomes INVALID, so later acquires for that PC have no effect.
- R7: An eviction makes every record with that address INVALID. Queued requests for the line are then granted without the expired flag, starting on the edge after the eviction.
- R8: When the queue already holds N_DEFER requests, a new request for a HELD line gets an immediate grant.
- R9: At most one queued request is granted per cycle. A request whose line is no longer HELD wins over an expired one, and the expired one follows in a later cycle.
- R10: A fill for a new PC takes the lowest-numbered INVALID record. If no record is INVALID, it replaces records in turn, starting from record 0. Replacing a HELD record frees the requests queued on its line.
- R11: A fill for the PC of a HELD record leaves it HELD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Lock line filled into the cache |
| fill_pc | input | PC_W | PC of the synchronizing instruction for the fill |
| fill_addr | input | ADDR_W | Line address of the fill |
| acq_valid | input | 1 | Predicted acquire |
| acq_pc | input | PC_W | PC of the acquire |
| acq_addr | input | ADDR_W | Line address of the acquire |
| rel_valid | input | 1 | Predicted release |
| rel_pc | input | PC_W | PC of the release |
| evict_valid | input | 1 | Line eviction or invalidation |
| evict_addr | input | ADDR_W | Line address evicted |
| req_valid | input | 1 | Incoming low-priority exclusive-read request |
| req_addr | input | ADDR_W | Requested line address |
| req_id | input | ID_W | Requester tag |
| imm_gnt_valid | output | 1 | Immediate grant |
| imm_gnt_id | output | ID_W | Tag of the immediately granted request |
| def_gnt_valid | output | 1 | Grant of a queued request |
| def_gnt_id | output | ID_W | Tag of the queued request granted |
| def_gnt_expired | output | 1 | The queued grant was forced by the timer |

## Verification
The bench builds the block with its defaults: four records, a four-deep queue and a 64-cycle timeout. Four records mean five distinct fills reach replacement, and a second round of replacement lands on a HELD record. The four-slot queue fills after four parked requests, so the overflow path to immediate grant is reached in a few cycles. The 64-cycle timeout is short enough to reach expiry by counting edges. It also allows a release to be placed on the exact edge where an older request expires, which tests the grant priority.

// File: rtl/lockq_pkg.sv
package lockq_pkg;

   typedef enum logic [1:0] {
      LK_INVALID = 2'd0,
      LK_PRESENT = 2'd1,
      LK_HELD    = 2'd2
   } lk_state_e;

endpackage

// File: rtl/lockq_held_match.sv
module lockq_held_match #(
   parameter int ADDR_W  = 32,
   parameter int N_ENTRY = 4
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [N_ENTRY-1:0]              ent_held,
   input  logic [N_ENTRY-1:0][ADDR_W-1:0]  ent_addr,
   output logic                            hit
);

   logic [N_ENTRY-1:0] match;

   for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
      assign match[g] = ent_held[g] && (ent_addr[g] == addr);
   end

   assign hit = |match;

endmodule

// File: rtl/lockq_state_table.sv
module lockq_state_table
   import lockq_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int ADDR_W  = 32,
   parameter int N_ENTRY = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            fill_valid,
   input  logic [PC_W-1:0]                 fill_pc,
   input  logic [ADDR_W-1:0]               fill_addr,
   input  logic                            acq_valid,
   input  logic [PC_W-1:0]                 acq_pc,
   input  logic [ADDR_W-1:0]               acq_addr,
   input  logic                            rel_valid,
   input  logic [PC_W-1:0]                 rel_pc,
   input  logic                            evict_valid,
   input  logic [ADDR_W-1:0]               evict_addr,
   input  logic                            drop_valid,
   input  logic [ADDR_W-1:0]               drop_addr,
   output logic [N_ENTRY-1:0]              ent_held,
   output logic [N_ENTRY-1:0][ADDR_W-1:0]  ent_addr
);

   localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

   lk_state_e         st_q   [N_ENTRY];
   lk_state_e         st_d   [N_ENTRY];
   logic [PC_W-1:0]   pc_q   [N_ENTRY];
   logic [PC_W-1:0]   pc_d   [N_ENTRY];
   logic [ADDR_W-1:0] addr_q [N_ENTRY];
   logic [ADDR_W-1:0] addr_d [N_ENTRY];
   logic [IDX_W-1:0]  rr_q, rr_d;

   always_comb begin
      logic             f_hit, f_free, a_found, r_found;
      logic [IDX_W-1:0] f_hit_idx, f_free_idx;
      st_d       = st_q;
      pc_d       = pc_q;
      addr_d     = addr_q;
      rr_d       = rr_q;
      f_hit      = 1'b0;
      f_free     = 1'b0;
      f_hit_idx  = '0;
      f_free_idx = '0;
      a_found    = 1'b0;
      r_found    = 1'b0;

      // fill: update by PC, else allocate free record, else rotate
      if (fill_valid) begin
         for (int i = 0; i < N_ENTRY; i++) begin
            if (!f_hit && st_q[i] != LK_INVALID && pc_q[i] == fill_pc) begin
               f_hit     = 1'b1;
               f_hit_idx = IDX_W'(i);
            end
            if (!f_free && st_q[i] == LK_INVALID) begin
               f_free     = 1'b1;
               f_free_idx = IDX_W'(i);
            end
         end
         if (f_hit) begin
            addr_d[f_hit_idx] = fill_addr;
            if (st_q[f_hit_idx] != LK_HELD) st_d[f_hit_idx] = LK_PRESENT;
         end else if (f_free) begin
            pc_d[f_free_idx]   = fill_pc;
            addr_d[f_free_idx] = fill_addr;
            st_d[f_free_idx]   = LK_PRESENT;
         end else begin
            pc_d[rr_q]   = fill_pc;
            addr_d[rr_q] = fill_addr;
            st_d[rr_q]   = LK_PRESENT;
            rr_d         = (rr_q == IDX_W'(N_ENTRY - 1)) ? '0 : rr_q + 1'b1;
         end
      end

      // predicted acquire: PRESENT -> HELD when PC and address agree
      if (acq_valid) begin
         for (int i = 0; i < N_ENTRY; i++) begin
            if (!a_found && st_d[i] != LK_INVALID && pc_d[i] == acq_pc) begin
               a_found = 1'b1;
               if (st_d[i] == LK_PRESENT && addr_d[i] == acq_addr) st_d[i] = LK_HELD;
            end
         end
      end

      // predicted release: HELD -> PRESENT by PC
      if (rel_valid) begin
         for (int i = 0; i < N_ENTRY; i++) begin
            if (!r_found && st_d[i] != LK_INVALID && pc_d[i] == rel_pc) begin
               r_found = 1'b1;
               if (st_d[i] == LK_HELD) st_d[i] = LK_PRESENT;
            end
         end
      end

      // eviction or invalidation of the line
      if (evict_valid) begin
         for (int i = 0; i < N_ENTRY; i++) begin
            if (st_d[i] != LK_INVALID && addr_d[i] == evict_addr) st_d[i] = LK_INVALID;
         end
      end

      // forced hand-over after timeout
      if (drop_valid) begin
         for (int i = 0; i < N_ENTRY; i++) begin
            if (st_d[i] == LK_HELD && addr_d[i] == drop_addr) st_d[i] = LK_INVALID;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ENTRY; i++) begin
            st_q[i]   <= LK_INVALID;
            pc_q[i]   <= '0;
            addr_q[i] <= '0;
         end
         rr_q <= '0;
      end else begin
         st_q   <= st_d;
         pc_q   <= pc_d;
         addr_q <= addr_d;
         rr_q   <= rr_d;
      end
   end

   for (genvar g = 0; g < N_ENTRY; g++) begin : g_out
      assign ent_held[g] = (st_q[g] == LK_HELD);
      assign ent_addr[g] = addr_q[g];
   end

endmodule

// File: rtl/lockq_defer_queue.sv
module lockq_defer_queue #(
   parameter int ADDR_W  = 32,
   parameter int ID_W    = 4,
   parameter int DEPTH   = 4,
   parameter int TIMEOUT = 64,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push_valid,
   input  logic [ADDR_W-1:0]             push_addr,
   input  logic [ID_W-1:0]               push_id,
   input  logic [DEPTH-1:0]              slot_held,
   output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
   output logic                          full,
   output logic [CNT_W-1:0]              occupancy,
   output logic                          gnt_valid,
   output logic [ID_W-1:0]               gnt_id,
   output logic                          gnt_expired,
   output logic                          drop_valid,
   output logic [ADDR_W-1:0]             drop_addr
);

   localparam int TMR_W = $clog2(TIMEOUT + 1);
   localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [ADDR_W-1:0] addr_d [DEPTH];
   logic [ID_W-1:0]   id_q   [DEPTH];
   logic [ID_W-1:0]   id_d   [DEPTH];
   logic [TMR_W-1:0]  tmr_q  [DEPTH];
   logic [TMR_W-1:0]  tmr_d  [DEPTH];

   logic              rel_hit, exp_hit, rm, rm_exp;
   logic [SEL_W-1:0]  rel_idx, exp_idx, rm_idx;
   logic [CNT_W-1:0]  base;
   logic              gnt_valid_q, gnt_exp_q;
   logic [ID_W-1:0]   gnt_id_q;

   // oldest released slot first, else oldest expired slot
   always_comb begin
      rel_hit = 1'b0;
      exp_hit = 1'b0;
      rel_idx = '0;
      exp_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (i < int'(cnt_q)) begin
            if (!rel_hit && !slot_held[i]) begin
               rel_hit = 1'b1;
               rel_idx = SEL_W'(i);
            end
            if (!exp_hit && tmr_q[i] == TMR_W'(TIMEOUT)) begin
               exp_hit = 1'b1;
               exp_idx = SEL_W'(i);
            end
         end
      end
   end

   assign rm         = rel_hit || exp_hit;
   assign rm_exp     = !rel_hit && exp_hit;
   assign rm_idx     = rel_hit ? rel_idx : exp_idx;
   assign drop_valid = rm_exp;
   assign drop_addr  = addr_q[exp_idx];
   assign full       = (cnt_q == CNT_W'(DEPTH));
   assign occupancy  = cnt_q;
   assign base       = cnt_q - CNT_W'(rm);

   // collapse the removed slot, age the rest, append the newcomer
   always_comb begin
      for (int j = 0; j < DEPTH; j++) begin
         int src;
         src = (rm && j >= int'(rm_idx)) ? j + 1 : j;
         if (src < DEPTH && src < int'(cnt_q)) begin
            addr_d[j] = addr_q[src];
            id_d[j]   = id_q[src];
            tmr_d[j]  = (tmr_q[src] == TMR_W'(TIMEOUT)) ? tmr_q[src] : tmr_q[src] + 1'b1;
         end else begin
            addr_d[j] = '0;
            id_d[j]   = '0;
            tmr_d[j]  = '0;
         end
      end
      cnt_d = base;
      if (push_valid && !full) begin
         addr_d[SEL_W'(base)] = push_addr;
         id_d[SEL_W'(base)]   = push_id;
         tmr_d[SEL_W'(base)]  = '0;
         cnt_d                = base + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         gnt_valid_q <= 1'b0;
         gnt_exp_q   <= 1'b0;
         gnt_id_q    <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= '0;
            id_q[i]   <= '0;
            tmr_q[i]  <= '0;
         end
      end else begin
         cnt_q       <= cnt_d;
         addr_q      <= addr_d;
         id_q        <= id_d;
         tmr_q       <= tmr_d;
         gnt_valid_q <= rm;
         gnt_exp_q   <= rm_exp;
         gnt_id_q    <= rm ? id_q[rm_idx] : '0;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign slot_addr[g] = addr_q[g];
   end

   assign gnt_valid   = gnt_valid_q;
   assign gnt_id      = gnt_id_q;
   assign gnt_expired = gnt_exp_q;

endmodule

// File: rtl/lockq_table.sv
module lockq_table #(
   parameter int PC_W    = 16,
   parameter int ADDR_W  = 32,
   parameter int ID_W    = 4,
   parameter int N_ENTRY = 4,
   parameter int N_DEFER = 4,
   parameter int TIMEOUT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   input  logic [PC_W-1:0]   fill_pc,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              acq_valid,
   input  logic [PC_W-1:0]   acq_pc,
   input  logic [ADDR_W-1:0] acq_addr,
   input  logic              rel_valid,
   input  logic [PC_W-1:0]   rel_pc,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ID_W-1:0]   req_id,
   output logic              imm_gnt_valid,
   output logic [ID_W-1:0]   imm_gnt_id,
   output logic              def_gnt_valid,
   output logic [ID_W-1:0]   def_gnt_id,
   output logic              def_gnt_expired
);

   localparam int OCC_W = $clog2(N_DEFER + 1);

   if (N_ENTRY < 2)  begin : g_bad_entry   $error("N_ENTRY must be at least 2");  end
   if (N_DEFER < 1)  begin : g_bad_defer   $error("N_DEFER must be at least 1");  end
   if (TIMEOUT < 2)  begin : g_bad_timeout $error("TIMEOUT must be at least 2");  end
   if (ID_W < 1 || PC_W < 1 || ADDR_W < 1) begin : g_bad_width $error("widths must be positive"); end

   logic [N_ENTRY-1:0]             ent_held;
   logic [N_ENTRY-1:0][ADDR_W-1:0] ent_addr;
   logic [N_DEFER-1:0][ADDR_W-1:0] slot_addr;
   logic [N_DEFER-1:0]             slot_held;
   logic                           req_held, q_full, drop_valid;
   logic [ADDR_W-1:0]              drop_addr;
   logic [OCC_W-1:0]               q_occ;
   logic                           push_valid;
   logic                           imm_valid_q;
   logic [ID_W-1:0]                imm_id_q;

   lockq_state_table #(
      .PC_W   (PC_W),
      .ADDR_W (ADDR_W),
      .N_ENTRY(N_ENTRY)
   ) table_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_valid (fill_valid),
      .fill_pc    (fill_pc),
      .fill_addr  (fill_addr),
      .acq_valid  (acq_valid),
      .acq_pc     (acq_pc),
      .acq_addr   (acq_addr),
      .rel_valid  (rel_valid),
      .rel_pc     (rel_pc),
      .evict_valid(evict_valid),
      .evict_addr (evict_addr),
      .drop_valid (drop_valid),
      .drop_addr  (drop_addr),
      .ent_held   (ent_held),
      .ent_addr   (ent_addr)
   );

   lockq_held_match #(.ADDR_W(ADDR_W), .N_ENTRY(N_ENTRY)) req_match_i (
      .addr    (req_addr),
      .ent_held(ent_held),
      .ent_addr(ent_addr),
      .hit     (req_held)
   );

   for (genvar g = 0; g < N_DEFER; g++) begin : g_slot_match
      lockq_held_match #(.ADDR_W(ADDR_W), .N_ENTRY(N_ENTRY)) slot_match_i (
         .addr    (slot_addr[g]),
         .ent_held(ent_held),
         .ent_addr(ent_addr),
         .hit     (slot_held[g])
      );
   end

   assign push_valid = req_valid && req_held && !q_full;

   lockq_defer_queue #(
      .ADDR_W (ADDR_W),
      .ID_W   (ID_W),
      .DEPTH  (N_DEFER),
      .TIMEOUT(TIMEOUT)
   ) queue_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (push_valid),
      .push_addr  (req_addr),
      .push_id    (req_id),
      .slot_held  (slot_held),
      .slot_addr  (slot_addr),
      .full       (q_full),
      .occupancy  (q_occ),
      .gnt_valid  (def_gnt_valid),
      .gnt_id     (def_gnt_id),
      .gnt_expired(def_gnt_expired),
      .drop_valid (drop_valid),
      .drop_addr  (drop_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imm_valid_q <= 1'b0;
         imm_id_q    <= '0;
      end else begin
         imm_valid_q <= req_valid && (!req_held || q_full);
         imm_id_q    <= req_id;
      end
   end

   assign imm_gnt_valid = imm_valid_q;
   assign imm_gnt_id    = imm_id_q;

endmodule

// File: rtl/lockq_table_chk.sv
module lockq_table_chk #(
   parameter int ID_W  = 4,
   parameter int OCC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [ID_W-1:0]  req_id,
   input logic             req_held,
   input logic             q_full,
   input logic [OCC_W-1:0] q_occ,
   input logic             imm_gnt_valid,
   input logic [ID_W-1:0]  imm_gnt_id,
   input logic             def_gnt_valid,
   input logic             def_gnt_expired
);

   AST_IMM_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      imm_gnt_valid |-> $past(req_valid));                               // R2

   AST_HELD_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_held && !q_full |=> !imm_gnt_valid);              // R3

   AST_FULL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && q_full |=> imm_gnt_valid && imm_gnt_id == $past(req_id)); // R8

   AST_EXPIRED_IS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      def_gnt_expired |-> def_gnt_valid);                                // R6

   AST_DEF_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      def_gnt_valid |-> $past(q_occ) != '0);                             // R5

endmodule

bind lockq_table lockq_table_chk #(.ID_W(ID_W), .OCC_W(OCC_W)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_id         (req_id),
   .req_held       (req_held),
   .q_full         (q_full),
   .q_occ          (q_occ),
   .imm_gnt_valid  (imm_gnt_valid),
   .imm_gnt_id     (imm_gnt_id),
   .def_gnt_valid  (def_gnt_valid),
   .def_gnt_expired(def_gnt_expired)
);

// File: tb/lockq_table_tb_top.sv
module lockq_table_tb_top;

   localparam int PC_W = 16, ADDR_W = 32, ID_W = 4, TMO = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fill_valid = 1'b0, acq_valid = 1'b0, rel_valid = 1'b0;
   logic              evict_valid = 1'b0, req_valid = 1'b0;
   logic [PC_W-1:0]   fill_pc = '0, acq_pc = '0, rel_pc = '0;
   logic [ADDR_W-1:0] fill_addr = '0, acq_addr = '0, evict_addr = '0, req_addr = '0;
   logic [ID_W-1:0]   req_id = '0;
   logic              imm_gnt_valid, def_gnt_valid, def_gnt_expired;
   logic [ID_W-1:0]   imm_gnt_id, def_gnt_id;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   lockq_table #(.PC_W(PC_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .TIMEOUT(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_pc(fill_pc), .fill_addr(fill_addr),
      .acq_valid(acq_valid), .acq_pc(acq_pc), .acq_addr(acq_addr),
      .rel_valid(rel_valid), .rel_pc(rel_pc),
      .evict_valid(evict_valid), .evict_addr(evict_addr),
      .req_valid(req_valid), .req_addr(req_addr), .req_id(req_id),
      .imm_gnt_valid(imm_gnt_valid), .imm_gnt_id(imm_gnt_id),
      .def_gnt_valid(def_gnt_valid), .def_gnt_id(def_gnt_id),
      .def_gnt_expired(def_gnt_expired)
   );

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic reset_dut();
      rst_n = 1'b0;
      steps(2);
      rst_n = 1'b1;
   endtask

   task automatic do_fill(int pc, int addr);
      fill_valid = 1'b1; fill_pc = PC_W'(pc); fill_addr = ADDR_W'(addr);
      step();
      fill_valid = 1'b0;
   endtask

   task automatic do_acq(int pc, int addr);
      acq_valid = 1'b1; acq_pc = PC_W'(pc); acq_addr = ADDR_W'(addr);
      step();
      acq_valid = 1'b0;
   endtask

   task automatic do_rel(int pc);
      rel_valid = 1'b1; rel_pc = PC_W'(pc);
      step();
      rel_valid = 1'b0;
   endtask

   task automatic do_evict(int addr);
      evict_valid = 1'b1; evict_addr = ADDR_W'(addr);
      step();
      evict_valid = 1'b0;
   endtask

   task automatic do_req(int addr, int id);
      req_valid = 1'b1; req_addr = ADDR_W'(addr); req_id = ID_W'(id);
      step();
      req_valid = 1'b0;
   endtask

   task automatic expect_def(string tag, int id, int expired);
      check({tag, " def valid"}, int'(def_gnt_valid), 1);
      check({tag, " def id"}, int'(def_gnt_id), id);
      check({tag, " def expired"}, int'(def_gnt_expired), expired);
   endtask

   task automatic t_reset();
      reset_dut();
      check("R1 imm low after reset", int'(imm_gnt_valid), 0);
      check("R1 def low after reset", int'(def_gnt_valid), 0);
      do_req('h100, 2);
      check("R1 imm on empty table", int'(imm_gnt_valid), 1);
      check("R1 imm id", int'(imm_gnt_id), 2);
   endtask

   task automatic t_present();
      reset_dut();
      do_fill('h10, 'hA0);
      do_req('hA0, 3);
      check("R2 imm on PRESENT", int'(imm_gnt_valid), 1);
      check("R2 imm id", int'(imm_gnt_id), 3);
   endtask

   task automatic t_hold_release();
      reset_dut();
      do_fill('h10, 'hA0);
      do_acq('h10, 'hA0);
      do_req('hA0, 1);
      check("R3 no imm on HELD", int'(imm_gnt_valid), 0);
      do_req('hA0, 2);
      check("R3 no imm second", int'(imm_gnt_valid), 0);
      check("R3 no def while HELD", int'(def_gnt_valid), 0);
      do_rel('h10);
      check("R5 no def on release edge", int'(def_gnt_valid), 0);
      step();
      expect_def("R5 first", 1, 0);
      step();
      expect_def("R5 second", 2, 0);
      step();
      check("R5 queue drained", int'(def_gnt_valid), 0);
   endtask

   task automatic t_acq_ignored();
      reset_dut();
      do_fill('h20, 'hB0);
      do_acq('h20, 'hB4);
      do_req('hB0, 4);
      check("R4 address mismatch ignored", int'(imm_gnt_valid), 1);
      do_acq('h21, 'hB0);
      do_req('hB0, 5);
      check("R4 unknown PC ignored", int'(imm_gnt_valid), 1);
   endtask

   task automatic t_timeout();
      reset_dut();
      do_fill('h30, 'hC0);
      do_acq('h30, 'hC0);
      do_req('hC0, 5);
      check("R6 queued", int'(imm_gnt_valid), 0);
      steps(TMO);
      check("R6 not yet expired", int'(def_gnt_valid), 0);
      step();
      expect_def("R6 expiry", 5, 1);
      do_acq('h30, 'hC0);
      do_req('hC0, 6);
      check("R6 line INVALID after expiry", int'(imm_gnt_valid), 1);
   endtask

   task automatic t_evict();
      reset_dut();
      do_fill('h40, 'hD0);
      do_acq('h40, 'hD0);
      do_req('hD0, 6);
      check("R7 queued", int'(imm_gnt_valid), 0);
      do_evict('hD0);
      check("R7 no def on evict edge", int'(def_gnt_valid), 0);
      step();
      expect_def("R7 after evict", 6, 0);
   endtask

   task automatic t_full();
      reset_dut();
      do_fill('h50, 'hE0);
      do_acq('h50, 'hE0);
      for (int i = 1; i <= 4; i++) begin
         do_req('hE0, i);
         check("R8 fill queue no imm", int'(imm_gnt_valid), 0);
      end
      do_req('hE0, 7);
      check("R8 full gives imm", int'(imm_gnt_valid), 1);
      check("R8 full imm id", int'(imm_gnt_id), 7);
      do_rel('h50);
      for (int i = 1; i <= 4; i++) begin
         step();
         expect_def("R9 one per cycle in order", i, 0);
      end
      step();
      check("R9 drained", int'(def_gnt_valid), 0);
   endtask

   task automatic t_priority();
      reset_dut();
      do_fill('h60, 'hF0);
      do_fill('h61, 'hF4);
      do_acq('h60, 'hF0);
      do_acq('h61, 'hF4);
      do_req('hF0, 8);
      do_req('hF4, 9);
      steps(TMO - 2);
      do_rel('h61);
      check("R9 nothing on collision edge", int'(def_gnt_valid), 0);
      step();
      expect_def("R9 released beats expired", 9, 0);
      step();
      expect_def("R9 expired follows", 8, 1);
   endtask

   task automatic t_replace();
      reset_dut();
      for (int i = 1; i <= 4; i++) do_fill('h70 + i, 'h200 + 4 * i);
      do_fill('h75, 'h214);
      do_acq('h71, 'h204);
      do_req('h204, 1);
      check("R10 first record replaced", int'(imm_gnt_valid), 1);
      do_acq('h72, 'h208);
      do_req('h208, 2);
      check("R10 second record still live", int'(imm_gnt_valid), 0);
      do_fill('h76, 'h218);
      check("R10 no def on replace edge", int'(def_gnt_valid), 0);
      step();
      expect_def("R10 replaced HELD frees queue", 2, 0);
   endtask

   task automatic t_refill_held();
      reset_dut();
      do_fill('h80, 'h300);
      do_acq('h80, 'h300);
      do_fill('h80, 'h300);
      do_req('h300, 3);
      check("R11 refill keeps HELD", int'(imm_gnt_valid), 0);
      do_rel('h80);
      step();
      expect_def("R11 release after refill", 3, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_present();
      t_hold_release();
      t_acq_ignored();
      t_timeout();
      t_evict();
      t_full();
      t_priority();
      t_replace();
      t_refill_held();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule